// File: doc/BRIEF.md
# Dual-PHY Register Write Handshake Engine

This block programs the control registers of two PHY instances after power-up. It drives one parallel address, data and write-enable bus that is steered to one PHY at a time, and each PHY answers on its own acknowledge line. Every transfer is a four-phase exchange. The address and data are placed on the bus first. The write enable then goes high and stays high until the acknowledge is seen high. The write enable then drops, and the engine waits for the acknowledge to go low before the next transfer begins.

A pulse on the start input asserts the interface-select line of both PHYs. After a settling period the engine runs a fixed script of eight writes. The four lanes of the first PHY are written first, then the four lanes of the second PHY. The lane address of each write is computed from a base address and a stride. Each of the two waits in a transfer has its own cycle limit. When a limit expires, a sticky timeout flag is raised and the script carries on. A done flag marks the end of the script. A new start pulse after done runs the script again.

Top module: `phy_cfg_writer`

## Requirements
- R1: During and after reset, with no start pulse yet: `sel_o`, `wr_en_o`, `busy_o`, `done_o` and `timeout_o` are all 0.
- R2: A start pulse sampled at a clock edge sets both `sel_o` bits and `busy_o` after that edge. The first write enable rises after the (SETTLE_CYC+1)-th following edge, where SETTLE_CYC defaults to 10. No write enable is ever high while a select bit is low.
- R3: A run issues exactly eight writes with data 0x0E21 (bits 11, 10, 9, 5 and 0 set). PHY index 0 is written first, with lanes 0, 1, 2 and 3 in turn, then PHY index 1 with the same lane order. The address of lane L is 0x1008 + 0x100*L.
- R4: The address and data are on the bus at least one cycle before the write enable rises, and they are stable while it stays high.
- R5: Only `wr_en_o[p]` of the PHY p being written can be high; the other bit stays 0.
- R6: `ack_i` passes through a two-flop synchroniser. After the acknowledge of the addressed PHY rises, the write enable stays high through two clock edges and is low after the third.
- R7: The next write enable rises only after the acknowledge of the previous transfer has gone low, unless that wait timed out.
- R8: If the acknowledge never rises, the write enable stays high for exactly ACK_TIMEOUT_CYC cycles and then drops. `timeout_o` is set, and the remaining writes still follow.
- R9: If the acknowledge stays high after the write enable drops, the engine waits ACK_TIMEOUT_CYC cycles and then sets `timeout_o`. For the last write, `done_o` rises ACK_TIMEOUT_CYC cycles after the write enable fell.
- R10: After the eighth transfer, `done_o` is 1 and `busy_o` is 0. `timeout_o` is 0 if no wait expired during the run.
- R11: A start pulse while `busy_o` is 1 has no effect on the script in progress.
- R12: A start pulse while `done_o` is 1 clears `done_o` and `timeout_o` after the sampling edge and runs the whole script again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when idle or done |
| ack_i | input | NUM_PHY | Acknowledge from each PHY, asynchronous |
| sel_o | output | NUM_PHY | Interface-select line to each PHY |
| wr_en_o | output | NUM_PHY | Write enable to each PHY, at most one bit set |
| addr_o | output | ADDR_W | Register address on the shared bus |
| wdata_o | output | DATA_W | Write data on the shared bus |
| busy_o | output | 1 | Script is running |
| done_o | output | 1 | Script finished; held until the next start |
| timeout_o | output | 1 | Sticky: an acknowledge wait expired in this run |

## Verification
The bench changes inputs one time unit after a falling edge and samples outputs on falling edges. A change made after rising edge k is therefore first seen at the next falling sample. The first write enable appears SETTLE_CYC+2 samples after the sample at which start was driven (R2). The write enable is low on the third sample after the acknowledge was raised (R6). A write enable with no acknowledge is high for exactly ACK_TIMEOUT_CYC samples (R8). Done appears ACK_TIMEOUT_CYC samples after the last write enable falls when the acknowledge is stuck high (R9). A PHY model answers with random latency from a fixed seed, and each transfer is compared with the script that bench functions compute.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_SETUP,
        ST_RAISE,
        ST_LOWER,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/phy_ack_sync.sv
module phy_ack_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    // Two flops per line; each bit is synchronised on its own.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;

endmodule

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             hit_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign hit_o = (cnt_q == limit_i);

    always_comb begin
        if (clear_i) begin
            cnt_d = '0;
        end else if (hit_o) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // The count never runs past the limit of the current wait (bounds R8/R9 windows).
    assert_cnt_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit_i);

endmodule

// File: rtl/phy_cfg_script.sv
module phy_cfg_script #(
    parameter int          NUM_PHY     = 2,
    parameter int          NUM_LANE    = 4,
    parameter int          ADDR_W      = 16,
    parameter int          DATA_W      = 16,
    parameter int unsigned LANE_BASE   = 32'h1008,
    parameter int unsigned LANE_STRIDE = 32'h0100,
    parameter int unsigned WR_VALUE    = 32'h0E21,
    localparam int TOTAL  = NUM_PHY * NUM_LANE,
    localparam int STEP_W = (TOTAL > 1) ? $clog2(TOTAL) : 1,
    localparam int PHY_W  = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1,
    localparam int LANE_W = (NUM_LANE > 1) ? $clog2(NUM_LANE) : 1
) (
    input  logic [STEP_W-1:0] step_i,
    output logic [PHY_W-1:0]  phy_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              last_o
);

    logic [LANE_W-1:0] lane;

    // Step order: lanes run fastest, so one PHY is finished before the next.
    assign phy_o  = PHY_W'(step_i / STEP_W'(NUM_LANE));
    assign lane   = LANE_W'(step_i % STEP_W'(NUM_LANE));
    assign addr_o = ADDR_W'(LANE_BASE) + ADDR_W'(lane) * ADDR_W'(LANE_STRIDE);
    assign data_o = DATA_W'(WR_VALUE);
    assign last_o = (step_i == STEP_W'(TOTAL - 1));

endmodule

// File: rtl/phy_cfg_writer.sv
module phy_cfg_writer
    import phy_cfg_pkg::*;
#(
    parameter int          NUM_PHY         = 2,
    parameter int          NUM_LANE        = 4,
    parameter int          ADDR_W          = 16,
    parameter int          DATA_W          = 16,
    parameter int unsigned LANE_BASE       = 32'h1008,
    parameter int unsigned LANE_STRIDE     = 32'h0100,
    parameter int unsigned WR_VALUE        = 32'h0E21,
    parameter int          SETTLE_CYC      = 10,
    parameter int          ACK_TIMEOUT_CYC = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [NUM_PHY-1:0] ack_i,
    output logic [NUM_PHY-1:0] sel_o,
    output logic [NUM_PHY-1:0] wr_en_o,
    output logic [ADDR_W-1:0]  addr_o,
    output logic [DATA_W-1:0]  wdata_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               timeout_o
);

    localparam int TOTAL   = NUM_PHY * NUM_LANE;
    localparam int STEP_W  = (TOTAL > 1) ? $clog2(TOTAL) : 1;
    localparam int PHY_W   = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1;
    localparam int MAX_WT  = (SETTLE_CYC > ACK_TIMEOUT_CYC) ? SETTLE_CYC : ACK_TIMEOUT_CYC;
    localparam int CNT_W   = $clog2(MAX_WT + 1);
    localparam logic [CNT_W-1:0] LIM_SETTLE = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] LIM_ACK    = CNT_W'(ACK_TIMEOUT_CYC - 1);

    typedef struct packed {
        seq_state_e         state;
        logic [STEP_W-1:0]  step;
        logic [NUM_PHY-1:0] sel;
        logic               tmo;
        logic               done;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [NUM_PHY-1:0] ack_s;
    logic               ack_sel;
    logic [PHY_W-1:0]   phy_idx;
    logic               last_step;
    logic               tmr_clear;
    logic               tmr_hit;
    logic [CNT_W-1:0]   tmr_limit;

    phy_ack_sync #(.WIDTH(NUM_PHY)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ack_i),
        .sync_o  (ack_s)
    );

    phy_cfg_script #(
        .NUM_PHY     (NUM_PHY),
        .NUM_LANE    (NUM_LANE),
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .LANE_BASE   (LANE_BASE),
        .LANE_STRIDE (LANE_STRIDE),
        .WR_VALUE    (WR_VALUE)
    ) u_script (
        .step_i (r_q.step),
        .phy_o  (phy_idx),
        .addr_o (addr_o),
        .data_o (wdata_o),
        .last_o (last_step)
    );

    cfg_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (tmr_clear),
        .limit_i (tmr_limit),
        .hit_o   (tmr_hit)
    );

    assign ack_sel = ack_s[phy_idx];

    always_comb begin
        unique case (r_q.state)
            ST_SETTLE:          tmr_limit = LIM_SETTLE;
            ST_RAISE, ST_LOWER: tmr_limit = LIM_ACK;
            default:            tmr_limit = '0;
        endcase
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    r_d.state = ST_SETTLE;
                    r_d.sel   = '1;
                    r_d.step  = '0;
                    r_d.tmo   = 1'b0;
                    r_d.done  = 1'b0;
                end
            end
            ST_SETTLE: begin
                if (tmr_hit) r_d.state = ST_SETUP;
            end
            ST_SETUP: begin
                r_d.state = ST_RAISE;
            end
            ST_RAISE: begin
                if (ack_sel) begin
                    r_d.state = ST_LOWER;
                end else if (tmr_hit) begin
                    r_d.state = ST_LOWER;
                    r_d.tmo   = 1'b1;
                end
            end
            ST_LOWER: begin
                if (!ack_sel || tmr_hit) begin
                    if (ack_sel) r_d.tmo = 1'b1;
                    if (last_step) begin
                        r_d.state = ST_DONE;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.state = ST_SETUP;
                        r_d.step  = r_q.step + STEP_W'(1);
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
        tmr_clear = (r_d.state != r_q.state);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, step: '0, sel: '0, tmo: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    for (genvar g = 0; g < NUM_PHY; g++) begin : g_wren
        assign wr_en_o[g] = (r_q.state == ST_RAISE) && (phy_idx == PHY_W'(g));
    end

    assign sel_o     = r_q.sel;
    assign busy_o    = (r_q.state != ST_IDLE) && (r_q.state != ST_DONE);
    assign done_o    = r_q.done;
    assign timeout_o = r_q.tmo;

    assert_single_wren_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en_o));

    assert_sel_before_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_en_o) |-> (&sel_o));

    assert_addr_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|wr_en_o) |-> ($stable(addr_o) && $stable(wdata_o)));

    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|wr_en_o) && $past(|wr_en_o)) |-> ($stable(addr_o) && $stable(wdata_o)));

    assert_drop_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|wr_en_o) |-> ($past(ack_sel) || timeout_o));

    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !(|wr_en_o)));

endmodule

// File: tb/tb_phy_cfg_writer.sv
module tb_phy_cfg_writer;

    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 10;
    localparam int TMO        = 48;
    localparam int NLANE      = 4;
    localparam int NWR        = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  ack = 2'b00;
    logic [1:0]  sel, wr_en;
    logic [15:0] addr, wdata;
    logic        busy, done, tmo_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    phy_cfg_writer #(
        .SETTLE_CYC      (SETTLE),
        .ACK_TIMEOUT_CYC (TMO)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .ack_i     (ack),
        .sel_o     (sel),
        .wr_en_o   (wr_en),
        .addr_o    (addr),
        .wdata_o   (wdata),
        .busy_o    (busy),
        .done_o    (done),
        .timeout_o (tmo_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [15:0] exp_addr(int k);
        return 16'h1008 + 16'h0100 * 16'(k % NLANE);
    endfunction

    function automatic int exp_phy(int k);
        return k / NLANE;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Monitor and PHY model state
    int          ng = 0;
    int          wcount = 0;
    int          hi_cnt = 0;
    int          ack_rise_ng = -1000;
    int          fall_ng = 0;
    int          done_ng = 0;
    int          start_ng = 0;
    int          stall_rise = -1;
    int          stall_fall = -1;
    int          cur_p = 0;
    int          lat = 0;
    logic [1:0]  prev_wr = 2'b00;
    logic        prev_done = 1'b0;
    logic [15:0] cap_addr, cap_data;

    always @(negedge clk) begin
        ng++;
        if (rst_n) begin
            if ((|wr_en) && !(|prev_wr)) begin
                int p;
                p = wr_en[1] ? 1 : 0;
                check(wr_en != 2'b11, "R5", "both enables high", wr_en, 0);
                check(p == exp_phy(wcount), "R5", "enabled phy", p, exp_phy(wcount));
                check(addr == exp_addr(wcount), "R3", "lane address", addr, exp_addr(wcount));
                check(wdata == 16'h0E21, "R3", "write data", wdata, 16'h0E21);
                check(ack == 2'b00, "R7", "ack low at enable rise", ack, 0);
                if (wcount == 0)
                    check(ng - start_ng == SETTLE + 2, "R2", "first enable delay",
                          ng - start_ng, SETTLE + 2);
                cap_addr    = addr;
                cap_data    = wdata;
                hi_cnt      = 0;
                ack_rise_ng = -1000;
                cur_p       = p;
                lat         = $urandom_range(0, 4);
            end
            if (|wr_en) begin
                hi_cnt++;
                if (addr != cap_addr || wdata != cap_data)
                    check(1'b0, "R4", "bus changed during enable", addr, cap_addr);
            end
            if (!(|wr_en) && (|prev_wr)) begin
                if (wcount == stall_rise) begin
                    check(hi_cnt == TMO, "R8", "enable width without ack", hi_cnt, TMO);
                    check(tmo_o == 1'b1, "R8", "timeout flag", tmo_o, 1);
                end else begin
                    check(ng - ack_rise_ng == 3, "R6", "enable drop after ack",
                          ng - ack_rise_ng, 3);
                end
                wcount++;
                fall_ng = ng;
                lat     = $urandom_range(0, 4);
            end
            if (done && !prev_done) done_ng = ng;
            // PHY model: answer the addressed PHY with random latency
            if (wr_en[cur_p] && !ack[cur_p] && wcount != stall_rise) begin
                if (lat == 0) begin
                    ack[cur_p]  = 1'b1;
                    ack_rise_ng = ng;
                end else begin
                    lat--;
                end
            end else if (!wr_en[cur_p] && ack[cur_p] && (wcount - 1) != stall_fall) begin
                if (lat == 0) ack[cur_p] = 1'b0;
                else lat--;
            end
        end
        prev_wr   = wr_en;
        prev_done = done;
    end

    task automatic run_script(int sr, int sf, bit exp_tmo, bit poke_start);
        int guard;
        stall_rise = sr;
        stall_fall = sf;
        wcount     = 0;
        @(negedge clk); #1;
        start    = 1'b1;
        start_ng = ng;
        @(negedge clk); #1;
        start = 1'b0;
        check(sel == 2'b11, "R2", "select lines after start", sel, 3);
        check(busy == 1'b1, "R2", "busy after start", busy, 1);
        check(done == 1'b0, "R12", "done cleared by start", done, 0);
        check(tmo_o == 1'b0, "R12", "timeout cleared by start", tmo_o, 0);
        if (poke_start) begin
            guard = 0;
            while (wcount < 3 && guard < 5000) begin
                @(negedge clk); guard++;
            end
            #1 start = 1'b1;
            @(negedge clk); #1 start = 1'b0;
            check(busy == 1'b1, "R11", "still busy after start while busy", busy, 1);
        end
        guard = 0;
        while (!done && guard < 5000) begin
            @(negedge clk); guard++;
        end
        #1;
        check(done == 1'b1, "R10", "done after script", done, 1);
        check(busy == 1'b0, "R10", "busy after script", busy, 0);
        check(wcount == NWR, "R3", "write count", wcount, NWR);
        check(tmo_o == exp_tmo, "R10", "timeout flag at end", tmo_o, exp_tmo);
        check(wr_en == 2'b00, "R10", "enables idle at end", wr_en, 0);
        if (sf >= 0) begin
            check(done_ng - fall_ng == TMO, "R9", "done delay with stuck ack",
                  done_ng - fall_ng, TMO);
            check(ack[1] == 1'b1, "R9", "ack still stuck", ack[1], 1);
        end
        stall_rise = -1;
        stall_fall = -1;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        #1;
        check(sel == 2'b00 && wr_en == 2'b00, "R1", "sel/wr_en in reset", {sel, wr_en}, 0);
        check(!busy && !done && !tmo_o, "R1", "flags in reset", {busy, done, tmo_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(sel == 2'b00 && wr_en == 2'b00, "R1", "sel/wr_en idle", {sel, wr_en}, 0);
        check(!busy && !done && !tmo_o, "R1", "flags idle", {busy, done, tmo_o}, 0);

        run_script(-1, -1, 1'b0, 1'b0);                       // R3 normal run
        run_script(-1, -1, 1'b0, 1'b1);                       // R11 start while busy
        run_script($urandom_range(0, 6), -1, 1'b1, 1'b0);     // R8 rising timeout
        run_script(-1, NWR - 1, 1'b1, 1'b0);                  // R9 falling timeout
        run_script(-1, -1, 1'b0, 1'b0);                       // R12 restart clears flag

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not end)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule